// File: doc/BRIEF.md
# Two-Lane Double-Precision Min/Max and Bitwise Unit

This block is a single-stage datapath that takes two 128-bit operands, each carrying two IEEE-754 double-precision values, and returns one 128-bit result. It chooses the larger or smaller value in each lane, or it combines the operands bit by bit with AND, AND-NOT, OR or XOR. The operation is picked by a 3-bit opcode that comes with every request.

A mode select chooses between packed and scalar operation. In packed mode both lanes are computed, each on its own. In scalar mode only the low lane is computed, and the upper lane of the result is a copy of the first operand's upper lane. The min/max compare works on the sign-magnitude encoding. Any NaN input, or a pair of zeros of either sign, makes the unit return the second operand's value.

The result sits in a register. A valid strobe marks each request and comes back on the output one clock later.

Top module: `fp2_minmax_logic`

## Requirements
- R1: Lane 0 is bits 63:0 and lane 1 is bits 127:64 of every operand and of the result. In packed mode (`in_packed`=1) each lane of the result depends only on the same lane of the two operands.
- R2: In scalar mode (`in_packed`=0) only lane 0 is computed, and result bits 127:64 equal `in_a` bits 127:64.
- R3: Opcode 0 (max) returns the numerically greater lane value. Positive values order by their magnitude bits, negative values order in reverse, and any negative value is below any positive one.
- R4: Opcode 1 (min) returns the numerically lesser lane value, using the same ordering as R3.
- R5: For max and min, if either lane input is a NaN (exponent all ones, fraction non-zero), the result lane is the `in_b` lane value.
- R6: For max and min, if both lane inputs are zeros of any sign, the result lane is the `in_b` lane value.
- R7: Opcodes 2, 3, 4 and 5 give `a & b`, `~a & b`, `a | b` and `a ^ b` bitwise on every computed lane.
- R8: Opcodes 6 and 7 are reserved and give all zeros on every computed lane.
- R9: `out_vld` is high exactly in the cycle after a cycle with `in_vld` high. `out_res` holds its value while no request arrives.
- R10: While reset is asserted, `out_vld` is low and `out_res` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe |
| in_op | input | 3 | Opcode (see R3, R4, R7, R8) |
| in_packed | input | 1 | 1 = both lanes, 0 = low lane only |
| in_a | input | 128 | First operand |
| in_b | input | 128 | Second operand |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_res | output | 128 | Registered result |

## Verification
On every cycle, the assertions check the one-cycle valid timing, that the result holds while idle, the scalar pass-through of the upper lane, that a min/max result is always one of the two inputs, and that a NaN in the first operand hands back the second. Only the bench scenarios can show that the right input wins. This covers sign-magnitude ordering across mixed signs, reversed ordering of negatives, signed zeros, the exact bit patterns of each logical opcode, and zeros for the reserved opcodes. The bench checks these against a reference model built on real-number comparison.

// File: rtl/fp2_pkg.sv
package fp2_pkg;

  typedef enum logic [2:0] {
    OPC_MAX  = 3'd0,
    OPC_MIN  = 3'd1,
    OPC_AND  = 3'd2,
    OPC_ANDN = 3'd3,
    OPC_OR   = 3'd4,
    OPC_XOR  = 3'd5,
    OPC_RSV6 = 3'd6,
    OPC_RSV7 = 3'd7
  } fp2_op_e;

endpackage

// File: rtl/fp2_rst_sync.sv
module fp2_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fp2_order.sv
module fp2_order #(
  parameter int LANE_W = 64,
  parameter int EXP_W  = 11
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic              a_lt_b,
  output logic              a_gt_b,
  output logic              take_b
);

  localparam int FRAC_W = LANE_W - 1 - EXP_W;
  localparam int MAG_W  = LANE_W - 1;

  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             nan_a, nan_b, zz;
  logic             mlt, mgt;

  always_comb begin
    sa    = a[LANE_W-1];
    sb    = b[LANE_W-1];
    ma    = a[MAG_W-1:0];
    mb    = b[MAG_W-1:0];
    nan_a = (&a[MAG_W-1 -: EXP_W]) && (|a[FRAC_W-1:0]);
    nan_b = (&b[MAG_W-1 -: EXP_W]) && (|b[FRAC_W-1:0]);
    zz    = (ma == '0) && (mb == '0);
    mlt   = ma < mb;
    mgt   = ma > mb;
    if (sa != sb) begin
      a_lt_b = sa;
      a_gt_b = sb;
    end else if (sa) begin
      a_lt_b = mgt;
      a_gt_b = mlt;
    end else begin
      a_lt_b = mlt;
      a_gt_b = mgt;
    end
    take_b = nan_a | nan_b | zz;
  end

endmodule

// File: rtl/fp2_lane_op.sv
module fp2_lane_op
  import fp2_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int EXP_W  = 11
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  fp2_op_e           op,
  output logic [LANE_W-1:0] y
);

  logic lt, gt, spec;

  fp2_order #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_order (
    .a      (a),
    .b      (b),
    .a_lt_b (lt),
    .a_gt_b (gt),
    .take_b (spec)
  );

  always_comb begin
    unique case (op)
      OPC_MAX:  y = (!spec && gt) ? a : b;
      OPC_MIN:  y = (!spec && lt) ? a : b;
      OPC_AND:  y = a & b;
      OPC_ANDN: y = ~a & b;
      OPC_OR:   y = a | b;
      OPC_XOR:  y = a ^ b;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/fp2_minmax_logic.sv
module fp2_minmax_logic
  import fp2_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 64,
  parameter int EXP_W  = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic [2:0]                in_op,
  input  logic                      in_packed,
  input  logic [LANES*LANE_W-1:0]   in_a,
  input  logic [LANES*LANE_W-1:0]   in_b,
  output logic                      out_vld,
  output logic [LANES*LANE_W-1:0]   out_res
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int FRAC_W = LANE_W - 1 - EXP_W;

  logic              rst_n_s;
  fp2_op_e           op;
  logic [DATA_W-1:0] lane_y;
  logic [DATA_W-1:0] res_d, res_q;
  logic              vld_d, vld_q;
  logic              res_en;

  fp2_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign op = fp2_op_e'(in_op);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] y;
    fp2_lane_op #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_op (
      .a  (in_a[g*LANE_W +: LANE_W]),
      .b  (in_b[g*LANE_W +: LANE_W]),
      .op (op),
      .y  (y)
    );
    if (g == 0) begin : g_low
      assign res_d[g*LANE_W +: LANE_W] = y;
    end else begin : g_high
      assign res_d[g*LANE_W +: LANE_W] = in_packed ? y : in_a[g*LANE_W +: LANE_W];
    end
    assign lane_y[g*LANE_W +: LANE_W] = y;

    AST_MINMAX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n_s)
      (in_vld && (in_op == 3'd0 || in_op == 3'd1) && (in_packed || g == 0)) |=>
      (out_res[g*LANE_W +: LANE_W] == $past(in_a[g*LANE_W +: LANE_W]) ||
       out_res[g*LANE_W +: LANE_W] == $past(in_b[g*LANE_W +: LANE_W]))); // R3

    AST_NAN_TAKES_B: assert property (@(posedge clk) disable iff (!rst_n_s)
      (in_vld && in_op[2:1] == 2'b00 && (in_packed || g == 0) &&
       (&in_a[g*LANE_W+LANE_W-2 -: EXP_W]) && (|in_a[g*LANE_W +: FRAC_W])) |=>
      (out_res[g*LANE_W +: LANE_W] == $past(in_b[g*LANE_W +: LANE_W]))); // R5
  end

  always_comb begin
    vld_d  = in_vld;
    res_en = in_vld;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign out_vld = vld_q;
  assign out_res = res_q;

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_vld |=> out_vld); // R9

  AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !in_vld |=> !out_vld); // R9

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !in_vld |=> $stable(out_res)); // R9

  AST_SCALAR_PASS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_vld && !in_packed) |=>
    (out_res[DATA_W-1:LANE_W] == $past(in_a[DATA_W-1:LANE_W]))); // R2

endmodule

// File: tb/tb_fp2_minmax_logic.sv
module tb_fp2_minmax_logic;

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN = 64'hFFF0000000000001;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] DEN  = 64'h0000000000000001;
  localparam logic [63:0] NDEN = 64'h8000000000000001;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [2:0]   in_op = 3'd0;
  logic         in_packed = 1'b1;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic         out_vld;
  logic [127:0] out_res;

  int n_chk = 0;
  int n_fail = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  fp2_minmax_logic dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
    .in_packed(in_packed), .in_a(in_a), .in_b(in_b),
    .out_vld(out_vld), .out_res(out_res)
  );

  function automatic bit is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  function automatic logic [63:0] ref_lane(input logic [63:0] a, input logic [63:0] b,
                                           input logic [2:0] op);
    real ra, rb;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    case (op)
      3'd0: return (is_nan(a) || is_nan(b)) ? b : ((ra > rb) ? a : b);
      3'd1: return (is_nan(a) || is_nan(b)) ? b : ((ra < rb) ? a : b);
      3'd2: return a & b;
      3'd3: return ~a & b;
      3'd4: return a | b;
      3'd5: return a ^ b;
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [2:0] op, input logic pk,
                      input logic [63:0] a1, input logic [63:0] a0,
                      input logic [63:0] b1, input logic [63:0] b0);
    logic [63:0] e1;
    @(negedge clk);
    in_vld = 1'b1; in_op = op; in_packed = pk;
    in_a = {a1, a0}; in_b = {b1, b0};
    e1 = pk ? ref_lane(a1, b1, op) : a1;
    exp_q.push_back({e1, ref_lane(a0, b0, op)});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected out_vld", {127'd0, out_vld}, 128'd0);
      end else begin
        logic [127:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_res, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    check("R10 reset out_vld", {127'd0, out_vld}, 128'd0);
    check("R10 reset out_res", out_res, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 idle after reset", {127'd0, out_vld}, 128'd0);

    // max / min ordering
    send("R3 max positives",       3'd0, 1'b1, P1, P2, P2, P1);
    send("R3 max negatives",       3'd0, 1'b1, N1, N2, N2, N1);
    send("R3 max mixed sign",      3'd0, 1'b1, N1, P1, P1, N2);
    send("R3 max inf denormal",    3'd0, 1'b1, PINF, NDEN, P2, DEN);
    send("R4 min negatives",       3'd1, 1'b1, N1, N2, N2, N1);
    send("R4 min mixed sign",      3'd1, 1'b1, P1, N1, N2, P2);
    send("R4 min denormals",       3'd1, 1'b1, DEN, NDEN, NDEN, DEN);
    // R1 lane independence: lanes see opposite orderings
    send("R1 lanes independent",   3'd0, 1'b1, P1, P2, P2, P1);
    // NaN
    send("R5 max nan in a",        3'd0, 1'b1, QNAN, SNAN, P1, N1);
    send("R5 min nan in b",        3'd1, 1'b1, N2, P2, QNAN, SNAN);
    // signed zeros
    send("R6 max zeros",           3'd0, 1'b1, PZ, NZ, NZ, PZ);
    send("R6 min zeros",           3'd1, 1'b1, NZ, PZ, PZ, NZ);
    // logic
    send("R7 and",  3'd2, 1'b1, 64'hF0F0_1234_FFFF_0000, 64'hAAAA_5555_0F0F_F0F0,
                                64'h0FF0_FFFF_00FF_FF00, 64'h5A5A_A5A5_FFFF_0000);
    send("R7 andn", 3'd3, 1'b1, 64'hF0F0_1234_FFFF_0000, 64'hAAAA_5555_0F0F_F0F0,
                                64'h0FF0_FFFF_00FF_FF00, 64'h5A5A_A5A5_FFFF_0000);
    send("R7 or",   3'd4, 1'b1, 64'hF0F0_1234_FFFF_0000, 64'hAAAA_5555_0F0F_F0F0,
                                64'h0FF0_FFFF_00FF_FF00, 64'h5A5A_A5A5_FFFF_0000);
    send("R7 xor",  3'd5, 1'b1, 64'hF0F0_1234_FFFF_0000, 64'hAAAA_5555_0F0F_F0F0,
                                64'h0FF0_FFFF_00FF_FF00, 64'h5A5A_A5A5_FFFF_0000);
    // reserved
    send("R8 reserved 6", 3'd6, 1'b1, P1, P2, N1, N2);
    send("R8 reserved 7", 3'd7, 1'b0, P1, P2, N1, N2);
    // scalar
    send("R2 scalar max",  3'd0, 1'b0, N2, N1, P2, N2);
    send("R2 scalar xor",  3'd5, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_FFFF_0000,
                                       64'hFFFF_FFFF_FFFF_FFFF, 64'h0F0F_0F0F_0F0F_0F0F);
    send("R2 scalar min nan", 3'd1, 1'b0, QNAN, QNAN, P1, P2);
    idle(3);

    // R9 hold: inputs change with no request
    held = out_res;
    in_a = {N1, N2}; in_b = {P1, P2}; in_op = 3'd4;
    repeat (3) @(negedge clk);
    check("R9 hold out_res", out_res, held);
    check("R9 no out_vld when idle", {127'd0, out_vld}, 128'd0);

    // R9 single-cycle pulse followed by idle
    send("R9 single request", 3'd4, 1'b1, P1, P2, N1, N2);
    idle(1);
    check("R9 out_vld one cycle after", {127'd0, out_vld}, 128'd1);
    @(negedge clk);
    check("R9 out_vld drops", {127'd0, out_vld}, 128'd0);
    idle(2);
    check("R9 scoreboard drained", {96'd0, exp_q.size()}, 128'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule